// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries a processor core into and out of an interrupt. In the idle state it watches four sources. The first is an edge-sensitive non-maskable pin. The second is a level-sensitive maskable request, which is gated by the interrupt-enable flag. The third is a software interrupt strobe that carries its own 8-bit type. The fourth is a return strobe. When a maskable request is accepted, the block runs a two-pulse acknowledge handshake and reads the 8-bit type from a byte-wide bus.

For any interrupt entry, the block then pushes three words onto the downward-growing stack at SS:SP, in this order: flags, code segment, instruction pointer. It next fetches the new instruction pointer and code segment from the vector table in low memory. When the sequence ends, it hands the new state back to the core with a one-cycle done strobe. A return pops the three words back in reverse order.

The core supplies its current flags, CS, IP, SS and SP on input ports. Memory is reached through one 16-bit word port. Writes take effect at the clock edge, and read data arrives in the cycle after the request.

Top module: `intr_seq`

## Requirements
- R1: After reset, busy, inta, mem_req and done are all 0.
- R2: A low-to-high transition on nmi_pin starts an entry with type 2, even when the interrupt-enable flag (bit 9 of cur_flags) is 0. Holding the pin high does not start a second entry.
- R3: When several sources are present in the same idle cycle, the order of precedence is: non-maskable edge, then maskable request, then software strobe, then return strobe.
- R4: intr_req is ignored while bit 9 of cur_flags is 0. In that case busy and inta stay 0.
- R5: An accepted maskable request drives inta high for exactly two separate one-cycle pulses. The type is the value on bus_type during the second pulse.
- R6: An entry writes three words with mem_we=1 at physical address SS*16+SP, with SP reduced by 2 before each write. The words are written in the order flags, CS, IP.
- R7: After the pushes, the new IP is read from address type*4 and the new CS from type*4+2.
- R8: An entry ends with done high for one cycle. At that point new_flags equals the saved flags with bit 9 (interrupt enable) and bit 8 (trap) cleared, and new_sp equals cur_sp-6.
- R9: A software entry uses sw_type unchanged as its type, including type 3.
- R10: A return reads IP, then CS, then flags, each from SS*16+SP with SP increased by 2 after each read. It performs no write and ends with done and new_sp=cur_sp+6. The restored flags are delivered unchanged.
- R11: A non-maskable edge that arrives while the block is busy is held pending. It is serviced as soon as the current sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin, rising-edge sensitive |
| intr_req | input | 1 | Maskable interrupt request, level |
| inta | output | 1 | Interrupt acknowledge pulse |
| bus_type | input | 8 | Type byte from the external controller |
| sw_req | input | 1 | Software interrupt strobe |
| sw_type | input | 8 | Type of the software interrupt |
| ret_req | input | 1 | Interrupt return strobe |
| cur_flags | input | 16 | Current flags word (bit 9 interrupt enable, bit 8 trap) |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 16 | Current instruction pointer |
| cur_ss | input | 16 | Current stack segment |
| cur_sp | input | 16 | Current stack pointer |
| busy | output | 1 | A sequence is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 20 | Physical byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| done | output | 1 | One-cycle strobe: the new_* outputs are valid |
| new_flags | output | 16 | Flags after the sequence |
| new_cs | output | 16 | Code segment after the sequence |
| new_ip | output | 16 | Instruction pointer after the sequence |
| new_sp | output | 16 | Stack pointer after the sequence |

## Verification
The assertions check several rules on every cycle. Acknowledge pulses last one cycle and never overlap a memory access. Memory is touched only while the block is busy. done is a single-cycle strobe that is seen only once the block is idle. A read that directly follows a push always targets the vector table. Other behaviour can only be shown by the bench's scenarios, because it depends on the stimulus: which source wins, the order and addresses of the stack words, the type read from the bus during the second pulse, the cleared flag bits, the pops of a return, and a non-maskable edge held across a busy sequence.

// File: rtl/intr_seq.sv
module intr_seq #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int TW = 8,
  parameter int IE_BIT = 9,
  parameter int TR_BIT = 8,
  parameter logic [7:0] NMI_TYPE = 8'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_pin,
  input  logic          intr_req,
  output logic          inta,
  input  logic [TW-1:0] bus_type,
  input  logic          sw_req,
  input  logic [TW-1:0] sw_type,
  input  logic          ret_req,
  input  logic [DW-1:0] cur_flags,
  input  logic [DW-1:0] cur_cs,
  input  logic [DW-1:0] cur_ip,
  input  logic [DW-1:0] cur_ss,
  input  logic [DW-1:0] cur_sp,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [DW-1:0] new_flags,
  output logic [DW-1:0] new_cs,
  output logic [DW-1:0] new_ip,
  output logic [DW-1:0] new_sp
);
  localparam int PAD = AW - DW - 4;
  localparam int VPAD = AW - TW - 2;
  localparam logic [DW-1:0] STEP = DW'(2);
  localparam logic [DW-1:0] CLR_MASK = ~((DW'(1) << IE_BIT) | (DW'(1) << TR_BIT));

  typedef enum logic [3:0] {
    S_IDLE, S_ACK1, S_GAP, S_ACK2,
    S_PFL, S_PCS, S_PIP, S_VIP, S_VCS, S_VWT,
    S_RIP, S_RCS, S_RFL, S_RWT
  } st_t;

  st_t           st;
  logic          nmi_q, nmi_pend;
  logic [TW-1:0] typ;
  logic [DW-1:0] r_fl, r_cs, r_ip, r_ss, r_sp;

  wire nmi_rise = nmi_pin & ~nmi_q;
  wire go_nmi   = nmi_pend | nmi_rise;
  wire go_intr  = intr_req & cur_flags[IE_BIT];
  wire idle     = (st == S_IDLE);
  wire take_nmi = idle & go_nmi;

  wire is_push = (st == S_PFL) | (st == S_PCS) | (st == S_PIP);
  wire is_pop  = (st == S_RIP) | (st == S_RCS) | (st == S_RFL);
  wire is_vec  = (st == S_VIP) | (st == S_VCS);

  wire [DW-1:0] sp_dec = r_sp - STEP;
  wire [DW-1:0] sp_use = is_push ? sp_dec : r_sp;
  wire [AW-1:0] stk_addr = {{PAD{1'b0}}, r_ss, 4'b0000} + {{(AW-DW){1'b0}}, sp_use};
  wire [AW-1:0] vec_addr = {{VPAD{1'b0}}, typ, 2'b00} + ((st == S_VCS) ? AW'(2) : AW'(0));

  assign busy    = ~idle;
  assign inta    = (st == S_ACK1) | (st == S_ACK2);
  assign mem_req = is_push | is_pop | is_vec;
  assign mem_we  = is_push;
  assign mem_addr = is_vec ? vec_addr : stk_addr;

  always_comb begin
    case (st)
      S_PFL:   mem_wdata = r_fl;
      S_PCS:   mem_wdata = r_cs;
      S_PIP:   mem_wdata = r_ip;
      default: mem_wdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_pin;
      nmi_pend <= (nmi_pend | nmi_rise) & ~take_nmi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      typ       <= '0;
      r_fl      <= '0;
      r_cs      <= '0;
      r_ip      <= '0;
      r_ss      <= '0;
      r_sp      <= '0;
      done      <= 1'b0;
      new_flags <= '0;
      new_cs    <= '0;
      new_ip    <= '0;
      new_sp    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go_nmi | go_intr | sw_req | ret_req) begin
            r_fl <= cur_flags;
            r_cs <= cur_cs;
            r_ip <= cur_ip;
            r_ss <= cur_ss;
            r_sp <= cur_sp;
          end
          if (go_nmi) begin
            typ <= NMI_TYPE;
            st  <= S_PFL;
          end else if (go_intr) begin
            st <= S_ACK1;
          end else if (sw_req) begin
            typ <= sw_type;
            st  <= S_PFL;
          end else if (ret_req) begin
            st <= S_RIP;
          end
        end
        S_ACK1: st <= S_GAP;
        S_GAP:  st <= S_ACK2;
        S_ACK2: begin
          typ <= bus_type;
          st  <= S_PFL;
        end
        S_PFL: begin
          r_sp <= sp_dec;
          st   <= S_PCS;
        end
        S_PCS: begin
          r_sp <= sp_dec;
          st   <= S_PIP;
        end
        S_PIP: begin
          r_sp <= sp_dec;
          st   <= S_VIP;
        end
        S_VIP: st <= S_VCS;
        S_VCS: begin
          r_ip <= mem_rdata;
          st   <= S_VWT;
        end
        S_VWT: begin
          new_ip    <= r_ip;
          new_cs    <= mem_rdata;
          new_flags <= r_fl & CLR_MASK;
          new_sp    <= r_sp;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        S_RIP: begin
          r_sp <= r_sp + STEP;
          st   <= S_RCS;
        end
        S_RCS: begin
          r_ip <= mem_rdata;
          r_sp <= r_sp + STEP;
          st   <= S_RFL;
        end
        S_RFL: begin
          r_cs <= mem_rdata;
          r_sp <= r_sp + STEP;
          st   <= S_RWT;
        end
        S_RWT: begin
          new_ip    <= r_ip;
          new_cs    <= r_cs;
          new_flags <= mem_rdata;
          new_sp    <= r_sp;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        inta,
  input logic        mem_req,
  input logic        mem_we,
  input logic [19:0] mem_addr,
  input logic        done
);
  a_r5_inta_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> !inta);

  a_r5_inta_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    inta |-> !mem_req);

  a_r11_mem_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_vec_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && $past(mem_req && mem_we)) |-> (mem_addr[19:10] == 10'd0));
endmodule

bind intr_seq intr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .inta(inta), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .done(done)
);

// File: tb/test_intr_seq.sv
module test_intr_seq;
  logic clk = 0, rst_n = 0;
  logic nmi_pin = 0, intr_req = 0, sw_req = 0, ret_req = 0;
  logic [7:0] bus_type, sw_type = 0;
  logic [15:0] cur_flags = 0, cur_cs = 0, cur_ip = 0, cur_ss = 16'h0040, cur_sp = 16'h0200;
  logic inta, busy, mem_req, mem_we, done;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, new_flags, new_cs, new_ip, new_sp;

  always #2.5 clk = ~clk;

  intr_seq i_intr_seq (.*);

  int total = 0, bad = 0, cycles = 0;
  logic [15:0] mem [0:2047];
  logic [19:0] wl_addr [0:7];
  logic [15:0] wl_data [0:7];
  int wcount = 0, inta_hi = 0, inta_rise = 0;
  logic inta_d = 0;
  logic [7:0] itype = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_req && mem_we) begin
      mem[mem_addr[11:1]] <= mem_wdata;
      if (wcount < 8) begin
        wl_addr[wcount] <= mem_addr;
        wl_data[wcount] <= mem_wdata;
      end
      wcount <= wcount + 1;
    end else if (mem_req) begin
      mem_rdata <= mem[mem_addr[11:1]];
    end
    inta_d <= inta;
    if (inta) inta_hi <= inta_hi + 1;
    if (inta && !inta_d) inta_rise <= inta_rise + 1;
  end

  always @(negedge clk) bus_type = (inta && inta_hi == 1) ? itype : 8'hEE;

  always @(posedge clk) if (cycles > 100000) begin
    bad++; total++;
    $display("FAIL watchdog R1..: act=%0d exp<100000", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    @(negedge clk);
    wcount = 0; inta_hi = 0; inta_rise = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  typedef struct packed { logic [7:0] t; logic [15:0] fl, cs, ip; } vec_t;
  localparam vec_t VECS [0:3] = '{
    '{8'h03, 16'h0202, 16'h1234, 16'h5678},
    '{8'h21, 16'h0302, 16'hABCD, 16'h0010},
    '{8'hFF, 16'h0FD5, 16'h0001, 16'hFFFE},
    '{8'h00, 16'h0000, 16'h8000, 16'h0002}
  };

  bit ok;
  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = (i % 2 == 0) ? 16'h1000 + 16'(i / 2) : 16'h2000 + 16'(i / 2);
    end
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 inta", inta, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 done", done, 0);
    rst_n = 1;

    for (int k = 0; k < 4; k++) begin
      clr_log();
      cur_flags = VECS[k].fl; cur_cs = VECS[k].cs; cur_ip = VECS[k].ip;
      sw_type = VECS[k].t; sw_req = 1;
      @(negedge clk); sw_req = 0;
      wait_done(ok);
      check("R8 done", ok, 1);
      check("R9 R7 new_ip", new_ip, 16'h1000 + 16'(VECS[k].t));
      check("R7 new_cs", new_cs, 16'h2000 + 16'(VECS[k].t));
      check("R8 new_flags", new_flags, VECS[k].fl & 16'hFCFF);
      check("R8 new_sp", new_sp, 16'h01FA);
      check("R6 count", wcount, 3);
      check("R6 flags addr", wl_addr[0], 20'h005FE);
      check("R6 flags data", wl_data[0], VECS[k].fl);
      check("R6 cs addr", wl_addr[1], 20'h005FC);
      check("R6 cs data", wl_data[1], VECS[k].cs);
      check("R6 ip addr", wl_addr[2], 20'h005FA);
      check("R6 ip data", wl_data[2], VECS[k].ip);
      @(negedge clk);
      check("R8 done pulse", done, 0);
    end

    // R10 return from the frame left by the last entry
    clr_log();
    mem[20'h005FA >> 1] = 16'hAAAA; mem[20'h005FC >> 1] = 16'hBBBB; mem[20'h005FE >> 1] = 16'h0202;
    cur_sp = 16'h01FA; ret_req = 1;
    @(negedge clk); ret_req = 0;
    wait_done(ok);
    check("R10 done", ok, 1);
    check("R10 ip", new_ip, 16'hAAAA);
    check("R10 cs", new_cs, 16'hBBBB);
    check("R10 flags", new_flags, 16'h0202);
    check("R10 sp", new_sp, 16'h0200);
    check("R10 no write", wcount, 0);
    cur_sp = 16'h0200;

    // R4 masked request ignored
    clr_log();
    cur_flags = 16'h0000; intr_req = 1;
    repeat (10) @(negedge clk);
    check("R4 busy", busy, 0);
    check("R4 inta", inta_hi, 0);
    intr_req = 0;

    // R5 acknowledge handshake
    clr_log();
    cur_flags = 16'h0200; itype = 8'h47; intr_req = 1;
    @(negedge clk); intr_req = 0;
    wait_done(ok);
    check("R5 done", ok, 1);
    check("R5 pulses", inta_rise, 2);
    check("R5 high cycles", inta_hi, 2);
    check("R5 type ip", new_ip, 16'h1047);
    check("R5 type cs", new_cs, 16'h2047);
    check("R8 if cleared", new_flags, 16'h0000);

    // R2 NMI with IE clear, then held high
    clr_log();
    cur_flags = 16'h0000; nmi_pin = 1;
    wait_done(ok);
    check("R2 done", ok, 1);
    check("R2 type2", new_ip, 16'h1002);
    clr_log();
    repeat (20) @(negedge clk);
    check("R2 no retrigger", busy, 0);
    check("R2 no write", wcount, 0);
    nmi_pin = 0;
    @(negedge clk);

    // R3 all sources together
    clr_log();
    cur_flags = 16'h0200; itype = 8'h55; sw_type = 8'h33;
    nmi_pin = 1; intr_req = 1; sw_req = 1; ret_req = 1;
    @(negedge clk); intr_req = 0; sw_req = 0; ret_req = 0;
    wait_done(ok);
    check("R3 done", ok, 1);
    check("R3 nmi wins", new_ip, 16'h1002);
    check("R3 no ack", inta_hi, 0);
    nmi_pin = 0;
    repeat (3) @(negedge clk);

    // R3 maskable over software
    clr_log();
    itype = 8'h60; sw_type = 8'h33; intr_req = 1; sw_req = 1;
    @(negedge clk); intr_req = 0; sw_req = 0;
    wait_done(ok);
    check("R3 intr wins", new_ip, 16'h1060);

    // R11 NMI edge during busy
    clr_log();
    sw_type = 8'h10; sw_req = 1;
    @(negedge clk); sw_req = 0;
    @(negedge clk); nmi_pin = 1;
    @(negedge clk); nmi_pin = 0;
    wait_done(ok);
    check("R11 first", new_ip, 16'h1010);
    wait_done(ok);
    check("R11 pending served", ok, 1);
    check("R11 type2", new_ip, 16'h1002);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule